// File: doc/BRIEF.md
# I/O Interrupt Redirection Controller

This block routes up to a parameterized number of external interrupt lines toward the processors of a system. Each line owns a 64-bit programmable entry. The entry names a destination, an addressing mode for that destination, a delivery type, a vector, a polarity and a trigger style, and it carries a mask bit. Software never sees the entries directly. It writes an index into a select register at offset 0x00 and then reads or writes a 32-bit data window at offset 0x10. The index chooses an identifier word, a read-only version word, or one half of one entry.

Lines in edge mode latch a rising input as pending. Lines in level mode simply track their input. A scheduler walks the unmasked pending lines in ascending order, starting from the line after the one it last served and wrapping at the top. It places one message per cycle into an output register with a valid/ready handshake. Once an edge line's message has been taken into that register, its pending state clears.

Top module: `ioredir_ctrl`

## Requirements
- R1: After reset, the select register and identifier read zero, every entry reads with only bit 16 (mask) set, and `msg_valid` is low.
- R2: Offset 0x00 reads back the 8-bit select value in bits 7:0 and is written from `reg_wdata[7:0]`. Any offset other than 0x00 and 0x10 reads zero.
- R3: Select 0x00 accesses the identifier in window bits 31:24, with all other bits reading zero. Select 0x01 reads `{8'h00, NUM_PINS-1, 8'h00, 8'h11}`, and writes to it change nothing.
- R4: Select 0x10+2n accesses bits 31:0 of entry n, and select 0x10+2n+1 accesses bits 63:32. A write replaces only the addressed half. Any other select value reads zero, and writes to it are dropped.
- R5: The entry fields are vector 7:0, delivery mode 10:8, destination mode 11, polarity 13, trigger 15 (1 = level), mask 16 and destination 63:56. The message carries each of these fields unchanged.
- R6: For an unmasked edge-mode line, each rising input produces exactly one message. An input that stays high produces no further messages.
- R7: For an unmasked level-mode line, messages repeat while the input is high and stop once it has been low for two cycles.
- R8: A masked line produces no message. A rise latched while the line is masked is delivered once after the mask is cleared.
- R9: Pending lines are served in ascending order from the line after the last one served, wrapping from the highest line to line 0.
- R10: While `msg_valid` is high and `msg_ready` is low, the message fields hold steady. A message is consumed only on a cycle where both signals are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | ADDR_W | Register offset (0x00 select, 0x10 window) |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data for `reg_addr` |
| irq_in | input | NUM_PINS | Interrupt input lines |
| msg_valid | output | 1 | Message available |
| msg_ready | input | 1 | Consumer accepts the message |
| msg_dest | output | 8 | Destination field |
| msg_dest_mode | output | 1 | Destination addressing mode |
| msg_deliv | output | 3 | Delivery mode |
| msg_vector | output | 8 | Vector |
| msg_polarity | output | 1 | Polarity bit |
| msg_trigger | output | 1 | Trigger style (1 = level) |

## Verification
The bench builds the block with NUM_PINS = 8 and ADDR_W = 8. With this value the version word becomes 0x00070011, so the pin-count field can be told apart from the default build. Select 0x20 falls just past the last entry, which lets the bench probe the unimplemented range right at its edge. The small pin count also means the round-robin pointer reaches the top line and wraps to line 0 within a few deliveries, so the bench can show a higher line being served before a lower one.

// File: rtl/ioredir_pkg.sv
package ioredir_pkg;

  localparam int ENT_W      = 64;
  localparam int F_VEC_LO   = 0;
  localparam int F_DM_LO    = 8;
  localparam int F_DSTMODE  = 11;
  localparam int F_POL      = 13;
  localparam int F_TRIG     = 15;
  localparam int F_MASK     = 16;
  localparam int F_DEST_LO  = 56;

  localparam logic [7:0] SEL_ID   = 8'h00;
  localparam logic [7:0] SEL_VER  = 8'h01;
  localparam logic [7:0] SEL_TBL  = 8'h10;
  localparam logic [7:0] VER_CODE = 8'h11;

  localparam logic [ENT_W-1:0] ENTRY_RST = 64'h1 << F_MASK;

  typedef struct packed {
    logic [7:0] dest;
    logic       dest_mode;
    logic [2:0] deliv;
    logic [7:0] vector;
    logic       polarity;
    logic       trigger;
  } msg_t;

  function automatic logic [31:0] version_word(input int pins);
    return {8'h00, 8'(pins - 1), 8'h00, VER_CODE};
  endfunction

  function automatic msg_t entry_to_msg(input logic [ENT_W-1:0] e);
    msg_t m;
    m.dest      = e[F_DEST_LO +: 8];
    m.dest_mode = e[F_DSTMODE];
    m.deliv     = e[F_DM_LO +: 3];
    m.vector    = e[F_VEC_LO +: 8];
    m.polarity  = e[F_POL];
    m.trigger   = e[F_TRIG];
    return m;
  endfunction

endpackage

// File: rtl/ioredir_regs.sv
module ioredir_regs
  import ioredir_pkg::*;
#(
  parameter int NUM_PINS = 24,
  parameter int ADDR_W   = 8
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [ADDR_W-1:0]               reg_addr,
  input  logic                            reg_wr,
  input  logic [31:0]                     reg_wdata,
  output logic [31:0]                     reg_rdata,
  output logic [NUM_PINS-1:0][ENT_W-1:0]  entries
);

  localparam logic [ADDR_W-1:0] OFF_SEL  = ADDR_W'(8'h00);
  localparam logic [ADDR_W-1:0] OFF_WIN  = ADDR_W'(8'h10);
  localparam logic [7:0]        SEL_LAST = 8'(16 + 2 * NUM_PINS - 1);

  logic [7:0]  sel_q, id_q;
  logic [7:0]  tbl_off;
  logic [6:0]  tbl_idx;
  logic        tbl_half, tbl_hit;
  logic        hit_sel, hit_win, sel_wr, win_wr;
  logic [31:0] win_data;

  assign hit_sel  = (reg_addr == OFF_SEL);
  assign hit_win  = (reg_addr == OFF_WIN);
  assign sel_wr   = reg_wr && hit_sel;
  assign win_wr   = reg_wr && hit_win;
  assign tbl_off  = sel_q - SEL_TBL;
  assign tbl_idx  = tbl_off[7:1];
  assign tbl_half = tbl_off[0];
  assign tbl_hit  = (sel_q >= SEL_TBL) && (sel_q <= SEL_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= '0;
      id_q  <= '0;
      for (int n = 0; n < NUM_PINS; n++) entries[n] <= ENTRY_RST;
    end else begin
      if (sel_wr) sel_q <= reg_wdata[7:0];
      if (win_wr && sel_q == SEL_ID) id_q <= reg_wdata[31:24];
      for (int n = 0; n < NUM_PINS; n++) begin
        if (win_wr && tbl_hit && tbl_idx == 7'(n)) begin
          if (tbl_half) entries[n][63:32] <= reg_wdata;
          else          entries[n][31:0]  <= reg_wdata;
        end
      end
    end
  end

  always_comb begin
    win_data = '0;
    if (sel_q == SEL_ID) win_data = {id_q, 24'h0};
    else if (sel_q == SEL_VER) win_data = version_word(NUM_PINS);
    else if (tbl_hit) begin
      for (int n = 0; n < NUM_PINS; n++)
        if (tbl_idx == 7'(n)) win_data = tbl_half ? entries[n][63:32] : entries[n][31:0];
    end
    if (hit_sel)      reg_rdata = {24'h0, sel_q};
    else if (hit_win) reg_rdata = win_data;
    else              reg_rdata = '0;
  end

  // R3: the version word is read-only, so a window write there leaves the identifier alone
  p_ver_readonly_r3: assert property (@(posedge clk) disable iff (!rst_n)
    win_wr && sel_q == SEL_VER |=> $stable(id_q));

  for (genvar g = 0; g < NUM_PINS; g++) begin : g_half
    // R4: a write to one half leaves the other half untouched
    p_low_keeps_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
      win_wr && tbl_hit && tbl_idx == 7'(g) && !tbl_half |=> $stable(entries[g][63:32]));
    p_high_keeps_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
      win_wr && tbl_hit && tbl_idx == 7'(g) && tbl_half |=> $stable(entries[g][31:0]));
  end

endmodule

// File: rtl/ioredir_pending.sv
module ioredir_pending #(
  parameter int NUM_PINS = 24
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] irq_in,
  input  logic [NUM_PINS-1:0] level_mode,
  input  logic [NUM_PINS-1:0] take,
  output logic [NUM_PINS-1:0] pend
);

  logic [NUM_PINS-1:0] irq_q;
  logic [NUM_PINS-1:0] rise;

  assign rise = irq_in & ~irq_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q <= '0;
      pend  <= '0;
    end else begin
      irq_q <= irq_in;
      pend  <= (level_mode & irq_in) | (~level_mode & ((pend & ~take) | rise));
    end
  end

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    // R6: once an edge line is taken and no new rise arrives, it is no longer pending
    p_edge_taken_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !level_mode[i] && take[i] && !rise[i] |=> !pend[i]);
    // R6: a steady high input never re-arms an idle edge line
    p_edge_no_rearm_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !level_mode[i] && !pend[i] && irq_q[i] && irq_in[i] |=> !pend[i]);
  end

endmodule

// File: rtl/ioredir_sched.sv
module ioredir_sched
  import ioredir_pkg::*;
#(
  parameter int NUM_PINS = 24
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [NUM_PINS-1:0]             eligible,
  input  logic [NUM_PINS-1:0][ENT_W-1:0]  entries,
  input  logic                            msg_ready,
  output logic                            msg_valid,
  output msg_t                            msg,
  output logic [NUM_PINS-1:0]             take
);

  localparam int IDX_W = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1;
  localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(NUM_PINS - 1);

  // Lowest line at or after start (wrapping); MSB of the result flags a hit.
  function automatic logic [IDX_W:0] pick_from(input logic [NUM_PINS-1:0] el,
                                               input logic [IDX_W-1:0] start);
    logic [IDX_W:0] r;
    int j;
    r = '0;
    for (int k = NUM_PINS - 1; k >= 0; k--) begin
      j = int'(start) + k;
      if (j >= NUM_PINS) j = j - NUM_PINS;
      if (el[j]) r = {1'b1, IDX_W'(j)};
    end
    return r;
  endfunction

  logic [IDX_W-1:0] ptr_q, pick;
  logic [IDX_W:0]   pick_r;
  logic             found, load;

  assign pick_r = pick_from(eligible, ptr_q);
  assign found  = pick_r[IDX_W];
  assign pick   = pick_r[IDX_W-1:0];
  assign load   = found && (!msg_valid || msg_ready);

  always_comb begin
    take = '0;
    if (load) take[pick] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      msg_valid <= 1'b0;
      msg       <= '0;
      ptr_q     <= '0;
    end else if (load) begin
      msg_valid <= 1'b1;
      msg       <= entry_to_msg(entries[pick]);
      ptr_q     <= (pick == TOP_IDX) ? '0 : pick + 1'b1;
    end else if (msg_valid && msg_ready) begin
      msg_valid <= 1'b0;
    end
  end

  // R10: a stalled message holds every field
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && !msg_ready |=> msg_valid && $stable(msg));
  // R9: at most one line is taken per cycle
  p_one_take_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(take));
  // R8: the line chosen for a message is never masked
  p_unmasked_r8: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !entries[pick][F_MASK]);

endmodule

// File: rtl/ioredir_ctrl.sv
module ioredir_ctrl
  import ioredir_pkg::*;
#(
  parameter int NUM_PINS = 24,
  parameter int ADDR_W   = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   reg_addr,
  input  logic                reg_wr,
  input  logic [31:0]         reg_wdata,
  output logic [31:0]         reg_rdata,
  input  logic [NUM_PINS-1:0] irq_in,
  output logic                msg_valid,
  input  logic                msg_ready,
  output logic [7:0]          msg_dest,
  output logic                msg_dest_mode,
  output logic [2:0]          msg_deliv,
  output logic [7:0]          msg_vector,
  output logic                msg_polarity,
  output logic                msg_trigger
);

  logic [NUM_PINS-1:0][ENT_W-1:0] entries;
  logic [NUM_PINS-1:0] mask_v, level_v, pend, take, eligible;
  msg_t msg;

  ioredir_regs #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .entries(entries));

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_fields
    assign mask_v[i]  = entries[i][F_MASK];
    assign level_v[i] = entries[i][F_TRIG];
  end

  ioredir_pending #(.NUM_PINS(NUM_PINS)) u_pending (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .level_mode(level_v),
    .take(take), .pend(pend));

  assign eligible = pend & ~mask_v;

  ioredir_sched #(.NUM_PINS(NUM_PINS)) u_sched (
    .clk(clk), .rst_n(rst_n), .eligible(eligible), .entries(entries),
    .msg_ready(msg_ready), .msg_valid(msg_valid), .msg(msg), .take(take));

  assign msg_dest      = msg.dest;
  assign msg_dest_mode = msg.dest_mode;
  assign msg_deliv     = msg.deliv;
  assign msg_vector    = msg.vector;
  assign msg_polarity  = msg.polarity;
  assign msg_trigger   = msg.trigger;

  // R8: nothing is taken from a masked line
  p_take_unmasked_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (take & mask_v) == '0);
  // R6: a taken line must have been pending
  p_take_pending_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (take & ~pend) == '0);

endmodule

// File: tb/ioredir_ctrl_bench.sv
module ioredir_ctrl_bench;

  localparam int NP = 8;
  localparam int N_VEC = 25;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] reg_addr = '0;
  logic reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [NP-1:0] irq_in = '0;
  logic msg_valid, msg_ready;
  logic [7:0] msg_dest, msg_vector;
  logic msg_dest_mode, msg_polarity, msg_trigger;
  logic [2:0] msg_deliv;

  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  ioredir_ctrl #(.NUM_PINS(NP), .ADDR_W(8)) u_ioredir_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_in(irq_in),
    .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_dest(msg_dest),
    .msg_dest_mode(msg_dest_mode), .msg_deliv(msg_deliv), .msg_vector(msg_vector),
    .msg_polarity(msg_polarity), .msg_trigger(msg_trigger));

  // {write, offset, wdata, expected read}
  localparam logic [72:0] VECS [0:N_VEC-1] = '{
    {1'b0, 8'h00, 32'h0, 32'h00000000},  // R1 R2 select resets to zero
    {1'b1, 8'h00, 32'h01, 32'h0},
    {1'b0, 8'h10, 32'h0, 32'h00070011},  // R3 version word
    {1'b1, 8'h10, 32'hFFFFFFFF, 32'h0},
    {1'b0, 8'h10, 32'h0, 32'h00070011},  // R3 version is read-only
    {1'b1, 8'h00, 32'h00, 32'h0},
    {1'b1, 8'h10, 32'hA5123456, 32'h0},
    {1'b0, 8'h10, 32'h0, 32'hA5000000},  // R3 identifier only in 31:24
    {1'b1, 8'h00, 32'h12, 32'h0},
    {1'b0, 8'h10, 32'h0, 32'h00010000},  // R1 entry low half masked at reset
    {1'b1, 8'h00, 32'h13, 32'h0},
    {1'b0, 8'h10, 32'h0, 32'h00000000},  // R1 entry high half zero at reset
    {1'b1, 8'h10, 32'hDEADBEEF, 32'h0},
    {1'b0, 8'h00, 32'h0, 32'h00000013},  // R2 select read-back
    {1'b1, 8'h00, 32'h12, 32'h0},
    {1'b0, 8'h10, 32'h0, 32'h00010000},  // R4 high write left low half alone
    {1'b1, 8'h10, 32'h00012345, 32'h0},
    {1'b0, 8'h10, 32'h0, 32'h00012345},  // R4 low half written
    {1'b1, 8'h00, 32'h13, 32'h0},
    {1'b0, 8'h10, 32'h0, 32'hDEADBEEF},  // R4 low write left high half alone
    {1'b1, 8'h00, 32'h20, 32'h0},
    {1'b1, 8'h10, 32'h12345678, 32'h0},
    {1'b0, 8'h10, 32'h0, 32'h00000000},  // R4 select past the table reads zero
    {1'b0, 8'h04, 32'h0, 32'h00000000},  // R2 other offset reads zero
    {1'b0, 8'h14, 32'h0, 32'h00000000}   // R2 other offset reads zero
  };

  // message log, sampled at the falling edge before the accepting rising edge
  logic [7:0] log_vec [0:1023];
  int n_log = 0;
  logic [7:0] last_dest;
  logic last_dm, last_pol, last_trig;
  logic [2:0] last_deliv;

  always @(negedge clk) begin
    if (rst_n && msg_valid && msg_ready && n_log < 1024) begin
      log_vec[n_log] = msg_vector;
      last_dest = msg_dest; last_dm = msg_dest_mode; last_pol = msg_polarity;
      last_trig = msg_trigger; last_deliv = msg_deliv;
      n_log++;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(posedge clk); #1;
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    @(posedge clk); #1;
    reg_addr = a; reg_wr = 1'b0;
    @(negedge clk);
    v = reg_rdata;
  endtask

  task automatic set_entry(input int n, input logic [31:0] lo, input logic [31:0] hi);
    wr(8'h00, 32'(16 + 2 * n + 1)); wr(8'h10, hi);
    wr(8'h00, 32'(16 + 2 * n));     wr(8'h10, lo);
  endtask

  task automatic drive_irq(input logic [NP-1:0] v);
    @(posedge clk); #1; irq_in = v;
  endtask

  task automatic set_ready(input logic v);
    @(posedge clk); #1; msg_ready = v;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
  endtask

  function automatic int count_vec(input logic [7:0] v, input int from);
    int c = 0;
    for (int k = from; k < n_log; k++) if (log_vec[k] == v) c++;
    return c;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int mark, cnt;
    msg_ready = 1'b1;
    idle(3);
    #1 rst_n = 1'b1;

    // R1 no message after reset
    @(negedge clk);
    chk("R1 msg_valid after reset", 32'(msg_valid), 32'h0);

    // register table walk
    for (int r = 0; r < N_VEC; r++) begin
      if (VECS[r][72]) wr(VECS[r][71:64], VECS[r][63:32]);
      else begin
        rd(VECS[r][71:64], v);
        chk($sformatf("table row %0d", r), v, VECS[r][31:0]);
      end
    end

    // R6 R5: edge line 0, vector 0x30, dest mode 1, polarity 1, dest 0x5A
    set_entry(0, 32'h0000_2830, 32'h5A00_0000);
    mark = n_log;
    drive_irq(8'h01);
    idle(10);
    chk("R6 one message per rise", 32'(count_vec(8'h30, mark)), 32'd1);
    chk("R5 dest", 32'(last_dest), 32'h5A);
    chk("R5 dest mode/polarity/trigger/deliv",
        {28'h0, last_dm, last_pol, last_trig, 1'b0} | {29'h0, last_deliv}, 32'h0000000C);
    drive_irq(8'h00);
    idle(2);
    drive_irq(8'h01);
    idle(6);
    chk("R6 second rise gives second message", 32'(count_vec(8'h30, mark)), 32'd2);
    drive_irq(8'h00);
    idle(3);

    // R7: level line 2, vector 0x41, delivery 3
    set_entry(2, 32'h0000_8341, 32'h0);
    mark = n_log;
    drive_irq(8'h04);
    idle(20);
    cnt = count_vec(8'h41, mark);
    chk("R7 repeats while high", 32'(cnt >= 5), 32'd1);
    chk("R5 level message trigger/deliv", {28'h0, last_trig, last_deliv}, 32'h0000000B);
    drive_irq(8'h00);
    idle(4);
    cnt = count_vec(8'h41, mark);
    idle(10);
    chk("R7 stops when low", 32'(count_vec(8'h41, mark)), 32'(cnt));

    // R8: masked edge line 3, vector 0x52
    set_entry(3, 32'h0001_0052, 32'h0);
    mark = n_log;
    drive_irq(8'h08);
    idle(10);
    chk("R8 masked gives no message", 32'(count_vec(8'h52, mark)), 32'd0);
    wr(8'h00, 32'h16); wr(8'h10, 32'h0000_0052);
    idle(6);
    chk("R8 latched rise delivered after unmask", 32'(count_vec(8'h52, mark)), 32'd1);
    drive_irq(8'h00);
    idle(3);

    // R9: lines 4..7 edge, vectors 0x64..0x67
    for (int p = 4; p < 8; p++) set_entry(p, 32'(8'h60 + p), 32'h0);
    mark = n_log;
    drive_irq(8'h50);
    idle(8);
    chk("R9 count", 32'(n_log - mark), 32'd2);
    chk("R9 first ascending", 32'(log_vec[mark]), 32'h64);
    chk("R9 second ascending", 32'(log_vec[mark + 1]), 32'h66);
    drive_irq(8'h00);
    idle(2);
    mark = n_log;
    drive_irq(8'hA0);
    idle(8);
    chk("R9 count after wrap", 32'(n_log - mark), 32'd2);
    chk("R9 pointer serves line 7 first", 32'(log_vec[mark]), 32'h67);
    chk("R9 wrap then line 5", 32'(log_vec[mark + 1]), 32'h65);
    drive_irq(8'h00);
    idle(2);

    // R10: stall with ready low
    set_ready(1'b0);
    mark = n_log;
    drive_irq(8'h10);
    idle(4);
    for (int s = 0; s < 3; s++) begin
      @(negedge clk);
      chk("R10 held valid", 32'(msg_valid), 32'h1);
      chk("R10 held vector", 32'(msg_vector), 32'h64);
    end
    chk("R10 nothing consumed while stalled", 32'(n_log - mark), 32'd0);
    set_ready(1'b1);
    idle(5);
    chk("R10 consumed once", 32'(n_log - mark), 32'd1);
    @(negedge clk);
    chk("R10 valid drops after consume", 32'(msg_valid), 32'h0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule